// File: doc/BRIEF.md
# Multiplexed Bus Write Sequencer

This block runs write cycles on an external bus where address and data share one set of wires. It signals in the direction-plus-strobe style: one line gives the transfer direction (low for a write) and one active-low data strobe marks when the data is valid. There are no separate read and write strobes. A requester offers an address, a data word and a chip-select index together with a request level. The block snapshots them and steps the bus through five phases: address (with the latch-enable pulse), a fixed one-cycle address hold, data setup, strobe, and hold. It then waits for a recovery gap before it can start the next access.

Each phase length comes from a configuration input that holds the count minus one, so zero means one cycle. The address, setup and hold fields are 2 bits wide (1 to 4 cycles). The strobe and recovery fields are 4 bits wide (1 to 16 cycles). All counts are in cycles of the block clock. The configuration is captured when an access is accepted, so a change takes effect only from the next access onward. The requester holds its request and payload until it sees the acknowledge pulse.

Top module: `mux_wr_seq`

## Requirements
- R1: During and after reset, with no request, every chip select is high, latch enable is low, the bus output enable is low, the direction line is high and the data strobe is high.
- R2: A request seen in idle at a rising edge makes latch enable high in the very next cycle. From then until the hold phase ends, exactly one chip select is low: the bit whose position equals the chip-select index.
- R3: Latch enable stays high for A+1 cycles, where A is the 2-bit address-phase field, and the bus carries the address throughout.
- R4: After latch enable falls, the address remains on the bus for exactly one cycle with the strobe still high, whatever the settings are.
- R5: Write data is on the bus for S+1 cycles before the strobe falls, where S is the 2-bit setup field.
- R6: The data strobe is low for T+1 cycles, where T is the 4-bit strobe field, and the data stays on the bus and unchanged while it is low.
- R7: After the strobe rises, chip select and data are held for H+1 cycles, where H is the 2-bit hold field.
- R8: The acknowledge is high for exactly one cycle per access, in the last hold cycle.
- R9: Whenever a chip select is low, the direction line is low and the bus output enable is high. Once the access ends, the output enable is low and the direction line and strobe are high.
- R10: Between two accesses, all chip selects stay high for exactly R+1 cycles, where R is the 4-bit recovery field, when the next request is already waiting before recovery ends. A request that arrives during recovery waits until recovery ends.
- R11: Changing the configuration inputs after an access has been accepted does not change any phase length of that access.
- R12: The data word is zero-extended to the bus width during the data phases, and the bus is as wide as the wider of address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, all phase counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request level, held until acknowledged |
| req_addr | input | ADDR_W (24) | Access address |
| req_data | input | DATA_W (16) | Write data |
| req_cs | input | CS_W (3) | Index of the chip select to drive |
| req_ack | output | 1 | One-cycle pulse in the last hold cycle |
| cfg_addr_len | input | A_W (2) | Address-phase cycles minus one |
| cfg_setup_len | input | S_W (2) | Setup cycles minus one |
| cfg_strobe_len | input | T_W (4) | Strobe cycles minus one |
| cfg_hold_len | input | H_W (2) | Hold cycles minus one |
| cfg_recov_len | input | R_W (4) | Recovery cycles minus one |
| bus_cs_n | output | CS_NUM (8) | Active-low chip selects |
| bus_ale | output | 1 | Address latch enable |
| bus_ad | output | BUS_W (24) | Shared address/data bus value |
| bus_ad_oe | output | 1 | Output enable for the shared bus |
| bus_rnw | output | 1 | Direction, low during a write |
| bus_ds_n | output | 1 | Active-low data strobe |

## Verification
The write sequence is driven with all-minimum fields, all-maximum fields and several mixed settings. Each phase length is measured from the pins, so an off-by-one in one counter load shows up in that phase alone and is not hidden by another. Every mixed setting also rewrites the configuration inputs with their complements in the middle of the access, which separates a snapshot taken at accept from a live read. Recovery is measured twice: once with the next request already pending at the acknowledge, and once with it raised part-way through recovery. The two cases tell apart a gap that counts from the end of the access from one that restarts at the request.

// File: rtl/mws_pkg.sv
package mws_pkg;

   // Bus phases in the order the sequencer walks them
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ADDR    = 3'd1,
      ST_AHOLD   = 3'd2,
      ST_SETUP   = 3'd3,
      ST_STROBE  = 3'd4,
      ST_HOLD    = 3'd5,
      ST_RECOVER = 3'd6
   } mws_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mws_phase_timer.sv
module mws_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign zero = (cnt == '0);

   // R6: an expired count stays at zero until reloaded, never wraps
   a_r6_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (zero && !load) |=> zero);

endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl import mws_pkg::*; #(
   parameter int A_W   = 2,
   parameter int S_W   = 2,
   parameter int T_W   = 4,
   parameter int H_W   = 2,
   parameter int R_W   = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             t_zero,
   input  logic [A_W-1:0]   live_addr_len,
   input  logic [S_W-1:0]   lat_setup,
   input  logic [T_W-1:0]   lat_strobe,
   input  logic [H_W-1:0]   lat_hold,
   input  logic [R_W-1:0]   lat_recov,
   output mws_state_e       state,
   output logic             accept,
   output logic             ack,
   output logic             t_load,
   output logic [CNT_W-1:0] t_val
);

   mws_state_e nxt;

   always_comb begin
      nxt    = state;
      accept = 1'b0;
      ack    = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               nxt    = ST_ADDR;
            end
         end
         ST_ADDR:   if (t_zero) nxt = ST_AHOLD;
         ST_AHOLD:  if (t_zero) nxt = ST_SETUP;
         ST_SETUP:  if (t_zero) nxt = ST_STROBE;
         ST_STROBE: if (t_zero) nxt = ST_HOLD;
         ST_HOLD: begin
            if (t_zero) begin
               ack = 1'b1;
               nxt = ST_RECOVER;
            end
         end
         ST_RECOVER: begin
            if (t_zero) begin
               if (req_valid) begin
                  accept = 1'b1;
                  nxt    = ST_ADDR;
               end else begin
                  nxt = ST_IDLE;
               end
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   // Load the shared timer with the length of the phase being entered
   always_comb begin
      t_load = (nxt != state);
      unique case (nxt)
         ST_ADDR:    t_val = CNT_W'(live_addr_len);
         ST_SETUP:   t_val = CNT_W'(lat_setup);
         ST_STROBE:  t_val = CNT_W'(lat_strobe);
         ST_HOLD:    t_val = CNT_W'(lat_hold);
         ST_RECOVER: t_val = CNT_W'(lat_recov);
         default:    t_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state <= ST_IDLE;
      else
         state <= nxt;
   end

   // R8: acknowledge never lasts two cycles
   a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);

   // R10: recovery is not cut short by a waiting request
   a_r10_recover_waits: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RECOVER && !t_zero) |=> state == ST_RECOVER);

   // R4: the address hold phase is always a single cycle
   a_r4_ahold_single: assert property (@(posedge clk) disable iff (rst)
      (state == ST_AHOLD) |=> state == ST_SETUP);

endmodule

// File: rtl/mws_pins.sv
module mws_pins import mws_pkg::*; #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int BUS_W  = 24,
   parameter int CS_NUM = 8,
   parameter int CS_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  mws_state_e        state,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [CS_W-1:0]   cs_idx,
   output logic [CS_NUM-1:0] cs_n,
   output logic              ale,
   output logic [BUS_W-1:0]  ad,
   output logic              ad_oe,
   output logic              rnw,
   output logic              ds_n
);

   logic             in_cycle;
   logic             addr_phase;
   logic             data_phase;
   logic [BUS_W-1:0] addr_ext;
   logic [BUS_W-1:0] data_ext;

   assign in_cycle   = state inside {ST_ADDR, ST_AHOLD, ST_SETUP, ST_STROBE, ST_HOLD};
   assign addr_phase = state inside {ST_ADDR, ST_AHOLD};
   assign data_phase = state inside {ST_SETUP, ST_STROBE, ST_HOLD};

   // Zero-extend whichever of address and data is narrower than the bus
   if (BUS_W > ADDR_W) begin : g_addr_pad
      assign addr_ext = {{(BUS_W-ADDR_W){1'b0}}, addr};
   end else begin : g_addr_full
      assign addr_ext = addr;
   end

   if (BUS_W > DATA_W) begin : g_data_pad
      assign data_ext = {{(BUS_W-DATA_W){1'b0}}, data};
   end else begin : g_data_full
      assign data_ext = data;
   end

   always_comb begin
      if (addr_phase)
         ad = addr_ext;
      else if (data_phase)
         ad = data_ext;
      else
         ad = '0;
   end

   assign ale   = (state == ST_ADDR);
   assign ad_oe = in_cycle;
   assign rnw   = !in_cycle;
   assign ds_n  = (state != ST_STROBE);

   for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
      assign cs_n[i] = !(in_cycle && (cs_idx == CS_W'(i)));
   end

   // R2: at most one chip select is driven at a time
   a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~cs_n));

   // R6: bus contents do not move while the strobe is low
   a_r6_strobe_data_stable: assert property (@(posedge clk) disable iff (rst)
      (!ds_n && $past(!ds_n)) |-> $stable(ad));

endmodule

// File: rtl/mux_wr_seq.sv
module mux_wr_seq import mws_pkg::*; #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int BUS_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
   parameter int CS_NUM = 8,
   parameter int CS_W   = $clog2(CS_NUM),
   parameter int A_W    = 2,
   parameter int S_W    = 2,
   parameter int T_W    = 4,
   parameter int H_W    = 2,
   parameter int R_W    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [CS_W-1:0]   req_cs,
   output logic              req_ack,
   input  logic [A_W-1:0]    cfg_addr_len,
   input  logic [S_W-1:0]    cfg_setup_len,
   input  logic [T_W-1:0]    cfg_strobe_len,
   input  logic [H_W-1:0]    cfg_hold_len,
   input  logic [R_W-1:0]    cfg_recov_len,
   output logic [CS_NUM-1:0] bus_cs_n,
   output logic              bus_ale,
   output logic [BUS_W-1:0]  bus_ad,
   output logic              bus_ad_oe,
   output logic              bus_rnw,
   output logic              bus_ds_n
);

   localparam int CNT_W = max2(max2(max2(A_W, S_W), max2(T_W, H_W)), R_W);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("mux_wr_seq: address and data widths must be positive");
   end
   if (BUS_W < ADDR_W || BUS_W < DATA_W) begin : g_bad_bus
      $error("mux_wr_seq: bus narrower than address or data");
   end
   if (CS_NUM < 2 || (1 << CS_W) < CS_NUM) begin : g_bad_cs
      $error("mux_wr_seq: chip-select count or index width invalid");
   end
   if (A_W < 1 || S_W < 1 || T_W < 1 || H_W < 1 || R_W < 1) begin : g_bad_fields
      $error("mux_wr_seq: phase field widths must be positive");
   end

   mws_state_e        state;
   logic              accept;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic              t_zero;

   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data;
   logic [CS_W-1:0]   lat_cs;
   logic [S_W-1:0]    lat_setup;
   logic [T_W-1:0]    lat_strobe;
   logic [H_W-1:0]    lat_hold;
   logic [R_W-1:0]    lat_recov;

   // Snapshot of payload and phase settings, taken once per access
   always_ff @(posedge clk) begin
      if (rst) begin
         lat_addr   <= '0;
         lat_data   <= '0;
         lat_cs     <= '0;
         lat_setup  <= '0;
         lat_strobe <= '0;
         lat_hold   <= '0;
         lat_recov  <= '0;
      end else if (accept) begin
         lat_addr   <= req_addr;
         lat_data   <= req_data;
         lat_cs     <= req_cs;
         lat_setup  <= cfg_setup_len;
         lat_strobe <= cfg_strobe_len;
         lat_hold   <= cfg_hold_len;
         lat_recov  <= cfg_recov_len;
      end
   end

   mws_ctrl #(
      .A_W(A_W), .S_W(S_W), .T_W(T_W), .H_W(H_W), .R_W(R_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .req_valid     (req_valid),
      .t_zero        (t_zero),
      .live_addr_len (cfg_addr_len),
      .lat_setup     (lat_setup),
      .lat_strobe    (lat_strobe),
      .lat_hold      (lat_hold),
      .lat_recov     (lat_recov),
      .state         (state),
      .accept        (accept),
      .ack           (req_ack),
      .t_load        (t_load),
      .t_val         (t_val)
   );

   mws_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   mws_pins #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .CS_NUM(CS_NUM), .CS_W(CS_W)
   ) u_pins (
      .clk    (clk),
      .rst    (rst),
      .state  (state),
      .addr   (lat_addr),
      .data   (lat_data),
      .cs_idx (lat_cs),
      .cs_n   (bus_cs_n),
      .ale    (bus_ale),
      .ad     (bus_ad),
      .ad_oe  (bus_ad_oe),
      .rnw    (bus_rnw),
      .ds_n   (bus_ds_n)
   );

   // R2: latch enable only rises in response to a request
   a_r2_ale_after_req: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_ale) |-> $past(req_valid));

   // R4: address still on the bus in the cycle after latch enable falls
   a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_ale) |-> (bus_ad_oe && bus_ds_n && $stable(bus_ad)));

   // R9: a selected device always sees a write direction and a driven bus
   a_r9_write_dir: assert property (@(posedge clk) disable iff (rst)
      (bus_cs_n != '1) |-> (!bus_rnw && bus_ad_oe));

   // R11: phase settings are frozen while the access is on the bus
   a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
      ((bus_cs_n != '1) && $past(bus_cs_n != '1))
         |-> ($stable(lat_setup) && $stable(lat_strobe) && $stable(lat_hold) && $stable(lat_recov)));

endmodule

// File: tb/sim_mux_wr_seq.sv
module sim_mux_wr_seq;

   localparam int ADDR_W = 24;
   localparam int DATA_W = 16;
   localparam int BUS_W  = 24;
   localparam int CS_NUM = 8;
   localparam int CS_W   = 3;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_data = '0;
   logic [CS_W-1:0]   req_cs = '0;
   logic              req_ack;
   logic [1:0]        cfg_addr_len = '0;
   logic [1:0]        cfg_setup_len = '0;
   logic [3:0]        cfg_strobe_len = '0;
   logic [1:0]        cfg_hold_len = '0;
   logic [3:0]        cfg_recov_len = '0;
   logic [CS_NUM-1:0] bus_cs_n;
   logic              bus_ale;
   logic [BUS_W-1:0]  bus_ad;
   logic              bus_ad_oe;
   logic              bus_rnw;
   logic              bus_ds_n;

   always #5 clk = ~clk;

   mux_wr_seq u0 (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data), .req_cs(req_cs),
      .req_ack(req_ack),
      .cfg_addr_len(cfg_addr_len), .cfg_setup_len(cfg_setup_len),
      .cfg_strobe_len(cfg_strobe_len), .cfg_hold_len(cfg_hold_len),
      .cfg_recov_len(cfg_recov_len),
      .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_ad(bus_ad),
      .bus_ad_oe(bus_ad_oe), .bus_rnw(bus_rnw), .bus_ds_n(bus_ds_n)
   );

   int checks = 0;
   int errors = 0;
   int wd = 0;

   typedef struct packed {
      logic [1:0]  a;
      logic [1:0]  s;
      logic [3:0]  t;
      logic [1:0]  h;
      logic [3:0]  r;
      logic [23:0] addr;
      logic [15:0] data;
      logic [2:0]  cs;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 4'd0,  2'd0, 4'd0,  24'h123456, 16'hA5A5, 3'd0},
      '{2'd3, 2'd3, 4'd15, 2'd3, 4'd15, 24'hFEDCBA, 16'h5A5A, 3'd7},
      '{2'd1, 2'd2, 4'd4,  2'd0, 4'd3,  24'h000001, 16'hFFFF, 3'd3},
      '{2'd2, 2'd0, 4'd9,  2'd2, 4'd7,  24'h800000, 16'h0001, 3'd5},
      '{2'd0, 2'd3, 4'd1,  2'd1, 4'd1,  24'h0F0F0F, 16'h1234, 3'd1},
      '{2'd3, 2'd1, 4'd0,  2'd3, 4'd0,  24'hAAAAAA, 16'h8000, 3'd6}
   };

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", wd);
         report();
         $finish;
      end
   end

   task automatic set_cfg(input logic [1:0] a, input logic [1:0] s, input logic [3:0] t,
                          input logic [1:0] h, input logic [3:0] r);
      cfg_addr_len   = a;
      cfg_setup_len  = s;
      cfg_strobe_len = t;
      cfg_hold_len   = h;
      cfg_recov_len  = r;
   endtask

   task automatic idle_pins(input string tag);
      chk(bus_cs_n == '1, tag, bus_cs_n, {CS_NUM{1'b1}});
      chk(!bus_ale && !bus_ad_oe && bus_rnw && bus_ds_n && !req_ack, tag,
          {bus_ale, bus_ad_oe, bus_rnw, bus_ds_n, req_ack}, 5'b00110);
   endtask

   // One access; phase lengths are measured from the pins
   task automatic run_vec(input vec_t v, input bit scramble);
      int n_ale, n_ah, n_su, n_st, n_ho, ack_n, ack_pos;
      bit seen_st, bad_cs, bad_dir, bad_addr, bad_data, done;
      logic [BUS_W-1:0] dexp;
      n_ale = 0; n_ah = 0; n_su = 0; n_st = 0; n_ho = 0; ack_n = 0; ack_pos = -1;
      seen_st = 0; bad_cs = 0; bad_dir = 0; bad_addr = 0; bad_data = 0; done = 0;
      dexp = BUS_W'(v.data);
      set_cfg(v.a, v.s, v.t, v.h, v.r);
      req_addr  = v.addr;
      req_data  = v.data;
      req_cs    = v.cs;
      req_valid = 1'b1;
      @(negedge clk);
      chk(bus_ale === 1'b1, "R2 latch enable in cycle after request", bus_ale, 1);
      for (int c = 0; c < 100 && !done; c++) begin
         if (bus_cs_n != '1) begin
            if (bus_cs_n != ~(CS_NUM'(1) << v.cs)) bad_cs = 1;
            if (bus_rnw !== 1'b0 || bus_ad_oe !== 1'b1) bad_dir = 1;
            if (bus_ale) begin
               n_ale++;
               if (bus_ad != BUS_W'(v.addr) || !bus_ds_n) bad_addr = 1;
            end else if (!seen_st && bus_ds_n && n_su == 0 && bus_ad == BUS_W'(v.addr)) begin
               n_ah++;
            end else if (!seen_st && bus_ds_n) begin
               n_su++;
               if (bus_ad != dexp) bad_data = 1;
            end else if (!bus_ds_n) begin
               seen_st = 1;
               n_st++;
               if (bus_ad != dexp) bad_data = 1;
            end else begin
               n_ho++;
               if (bus_ad != dexp) bad_data = 1;
            end
            if (req_ack) begin
               ack_n++;
               ack_pos = (seen_st && bus_ds_n) ? n_ho : -1;
               req_valid = 1'b0;
            end
            if (scramble) set_cfg(~v.a, ~v.s, ~v.t, ~v.h, ~v.r);
            @(negedge clk);
         end else begin
            done = 1;
         end
      end
      chk(n_ale == int'(v.a) + 1, "R3 latch enable length", n_ale, int'(v.a) + 1);
      chk(!bad_addr, "R3 address on bus during latch enable", bad_addr, 0);
      chk(n_ah == 1, "R4 address hold after latch enable", n_ah, 1);
      chk(n_su == int'(v.s) + 1, "R5 data setup length", n_su, int'(v.s) + 1);
      chk(n_st == int'(v.t) + 1, "R6 strobe length", n_st, int'(v.t) + 1);
      chk(n_ho == int'(v.h) + 1, "R7 hold length", n_ho, int'(v.h) + 1);
      chk(ack_n == 1 && ack_pos == int'(v.h) + 1, "R8 single ack in last hold cycle",
          ack_pos, int'(v.h) + 1);
      chk(!bad_cs, "R2 only the indexed chip select low", bad_cs, 0);
      chk(!bad_dir, "R9 direction low and bus driven during access", bad_dir, 0);
      chk(!bad_data, "R12 zero-extended data on bus", bad_data, 0);
      idle_pins("R9 pins quiet after access");
      if (scramble)
         chk(n_ale == int'(v.a) + 1 && n_su == int'(v.s) + 1 && n_st == int'(v.t) + 1 &&
             n_ho == int'(v.h) + 1, "R11 lengths unchanged by mid-access config",
             {n_ale, n_su}, {int'(v.a) + 1, int'(v.s) + 1});
      repeat (20) @(negedge clk);
   endtask

   // Two accesses; the chip-select gap between them is measured
   task automatic gap_test(input int rec, input int delay);
      int gap;
      set_cfg(2'd0, 2'd0, 4'd0, 2'd0, 4'(rec));
      req_addr  = 24'h00ABCD;
      req_data  = 16'h1111;
      req_cs    = 3'd2;
      req_valid = 1'b1;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (req_ack) break;
      end
      req_addr = 24'h654321;
      req_data = 16'h2222;
      req_cs   = 3'd4;
      if (delay > 0) req_valid = 1'b0;
      gap = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (bus_cs_n == '1) begin
            gap++;
            if (delay > 0 && gap == delay) req_valid = 1'b1;
         end else begin
            break;
         end
      end
      chk(gap == rec + 1, "R10 chip-select gap equals recovery", gap, rec + 1);
      chk(bus_ale && bus_ad == BUS_W'(24'h654321) && bus_cs_n == ~(CS_NUM'(1) << 4),
          "R2 second access starts with its own address and select", bus_ad, 24'h654321);
      for (int c = 0; c < 60; c++) begin
         if (req_ack) break;
         @(negedge clk);
      end
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      idle_pins("R1 outputs during reset");
      rst = 1'b0;
      repeat (3) @(negedge clk);
      idle_pins("R1 outputs idle after reset");

      for (int i = 0; i < NV; i++) begin
         run_vec(VECS[i], (i >= 2));
      end

      gap_test(5, 0);
      gap_test(5, 3);
      gap_test(0, 0);
      gap_test(15, 0);

      report();
      $finish;
   end

endmodule